// File: doc/BRIEF.md
# Clock Frequency Watchdog with Safe-Code Fallback

This block watches over the frequency selection of a programmable clock generator. Once armed, it counts down a programmable number of coarse time units. Each unit is delivered as a single-cycle `unit_tick_i` pulse. Software must restart the count with `kick_i` before it runs out. If the count expires, the block raises an alarm and replaces the normal 5-bit frequency-select code with a safe code. The safe code comes from one of two sources: the strap value latched at power-up, or a programmed safe field. In the target system each unit is 290 ms, and the power-up count of 8 gives about 2.3 s. A bench can use much shorter ticks.

The block is armed by an effective enable. While software has not taken control, the effective enable follows the strap latched at power-up. Once software asserts its override, the software enable bit decides instead. The block is a three-state machine:

- IDLE: disarmed.
- RUN: counting down.
- ALARM: expired.

Its transitions are:

- arm: IDLE to RUN, loading the count.
- zero-arm: IDLE to ALARM, taken when the count is 0.
- restart: RUN to RUN, reloading the count on a kick.
- expire: RUN to ALARM, on the tick that ends the count.
- clear: ALARM to RUN, reloading the count, or to ALARM again when the count is 0.
- disarm: RUN or ALARM to IDLE, whenever the effective enable drops.

Top module: `clkwd_top`

## Requirements
- R1: After reset the alarm output is 0 and `freq_code_o` equals `norm_code_i`.
- R2: The effective enable is `cfg_sw_en_i` when `cfg_sw_ovr_i` is 1, and `strap_en_i` when it is 0.
- R3: When armed with a nonzero count N, the alarm rises at the clock edge that samples the N-th tick pulse after arming. It does not rise earlier.
- R4: A kick while running reloads the full count. A kick in the same cycle as a tick takes priority, and that tick is not counted.
- R5: `alarm_o` is 1 exactly while the machine is in the expired state.
- R6: In alarm with `cfg_safe_sel_i` = 0, `freq_code_o` equals `strap_code_i`.
- R7: In alarm with `cfg_safe_sel_i` = 1, `freq_code_o` equals `cfg_safe_code_i`. This field uses the same 5-bit encoding as the normal code.
- R8: While not in alarm, `freq_code_o` equals `norm_code_i`.
- R9: Once set, the alarm stays set through ticks and kicks for as long as the block is enabled and no clear arrives.
- R10: A clear pulse in alarm drops the alarm at the next edge and restarts a full countdown.
- R11: Dropping the effective enable returns the block to idle at the next edge and clears any alarm.
- R12: Arming with a count of 0 raises the alarm at the very next edge, with no tick needed.
- R13: Tick pulses while disarmed have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| unit_tick_i | input | 1 | One-cycle pulse per time unit |
| kick_i | input | 1 | Restart strobe |
| alarm_clr_i | input | 1 | Software alarm clear pulse |
| strap_en_i | input | 1 | Enable latched from strap at power-up |
| cfg_sw_ovr_i | input | 1 | Software has taken control of enable |
| cfg_sw_en_i | input | 1 | Software enable value |
| cfg_count_i | input | 8 | Timeout in time units |
| cfg_safe_sel_i | input | 1 | Safe source: 0 strap, 1 programmed field |
| cfg_safe_code_i | input | 5 | Programmed safe frequency code |
| strap_code_i | input | 5 | Frequency code latched from straps |
| norm_code_i | input | 5 | Normally selected frequency code |
| freq_code_o | output | 5 | Effective frequency code |
| alarm_o | output | 1 | Alarm status |

## Verification
The hardest situation to reach is the alarm while the block remains enabled. It takes a full countdown, and its exit paths then have to be separated from one another: kick, clear, disarm and source switch. The stimulus reaches it by arming with small counts and delivering counted tick pulses. A kick is also delivered in the same cycle as a tick, to show the tick is lost. The zero count is exercised separately, as an immediate expiry on arming.

// File: rtl/clkwd_pkg.sv
package clkwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_ALARM = 2'd2
    } wd_state_e;
endpackage

// File: rtl/clkwd_enable_sel.sv
module clkwd_enable_sel (
    input  logic strap_en_i,
    input  logic sw_ovr_i,
    input  logic sw_en_i,
    output logic en_o
);
    // Software enable wins once software has taken control
    always_comb en_o = sw_ovr_i ? sw_en_i : strap_en_i;
endmodule

// File: rtl/clkwd_downcnt.sv
module clkwd_downcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             dec_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             at_one_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else if (dec_i)  cnt_q <= cnt_q - ONE;
    end

    assign cnt_o    = cnt_q;
    assign at_one_o = (cnt_q == ONE);
endmodule

// File: rtl/clkwd_code_mux.sv
module clkwd_code_mux #(
    parameter int CODE_W = 5
) (
    input  logic              alarm_i,
    input  logic              safe_sel_i,
    input  logic [CODE_W-1:0] safe_code_i,
    input  logic [CODE_W-1:0] strap_code_i,
    input  logic [CODE_W-1:0] norm_code_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] safe_pick;

    always_comb begin
        safe_pick = safe_sel_i ? safe_code_i : strap_code_i;
        code_o    = alarm_i ? safe_pick : norm_code_i;
    end
endmodule

// File: rtl/clkwd_top.sv
module clkwd_top
    import clkwd_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              unit_tick_i,
    input  logic              kick_i,
    input  logic              alarm_clr_i,
    input  logic              strap_en_i,
    input  logic              cfg_sw_ovr_i,
    input  logic              cfg_sw_en_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic              cfg_safe_sel_i,
    input  logic [CODE_W-1:0] cfg_safe_code_i,
    input  logic [CODE_W-1:0] strap_code_i,
    input  logic [CODE_W-1:0] norm_code_i,
    output logic [CODE_W-1:0] freq_code_o,
    output logic              alarm_o
);
    wd_state_e        state_q, state_d;
    logic             en_eff;
    logic             cnt_load, cnt_dec, cnt_at_one;
    logic [CNT_W-1:0] cnt_val;
    logic             cfg_zero;

    assign cfg_zero = (cfg_count_i == '0);

    clkwd_enable_sel u_en (
        .strap_en_i (strap_en_i),
        .sw_ovr_i   (cfg_sw_ovr_i),
        .sw_en_i    (cfg_sw_en_i),
        .en_o       (en_eff)
    );

    clkwd_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .dec_i      (cnt_dec),
        .load_val_i (cfg_count_i),
        .cnt_o      (cnt_val),
        .at_one_o   (cnt_at_one)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_eff) begin
                    cnt_load = 1'b1;
                    state_d  = cfg_zero ? ST_ALARM : ST_RUN;
                end
            end
            ST_RUN: begin
                if (!en_eff) begin
                    state_d = ST_IDLE;
                end else if (kick_i) begin
                    cnt_load = 1'b1;
                    if (cfg_zero) state_d = ST_ALARM;
                end else if (unit_tick_i) begin
                    if (cnt_at_one) state_d = ST_ALARM;
                    else            cnt_dec = 1'b1;
                end
            end
            ST_ALARM: begin
                if (!en_eff) begin
                    state_d = ST_IDLE;
                end else if (alarm_clr_i) begin
                    cnt_load = 1'b1;
                    state_d  = cfg_zero ? ST_ALARM : ST_RUN;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb alarm_o = (state_q == ST_ALARM);

    clkwd_code_mux #(.CODE_W(CODE_W)) u_mux (
        .alarm_i      (alarm_o),
        .safe_sel_i   (cfg_safe_sel_i),
        .safe_code_i  (cfg_safe_code_i),
        .strap_code_i (strap_code_i),
        .norm_code_i  (norm_code_i),
        .code_o       (freq_code_o)
    );

    AST_RUN_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN) |-> (cnt_val != '0)); // R3
    AST_ZERO_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && en_eff && cfg_zero) |=> alarm_o); // R12
    AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_o && en_eff && !alarm_clr_i) |=> alarm_o); // R9
    AST_DISARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_eff |=> !alarm_o); // R11
    AST_NORMAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !alarm_o |-> (freq_code_o == norm_code_i)); // R8
    AST_STRAP_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_o && !cfg_safe_sel_i) |-> (freq_code_o == strap_code_i)); // R6
    AST_KICK_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && en_eff && kick_i) |=> (cnt_val == $past(cfg_count_i))); // R4
endmodule

// File: tb/clkwd_top_tb_top.sv
module clkwd_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, kick = 1'b0, clr = 1'b0;
    logic       strap_en = 1'b0, sw_ovr = 1'b0, sw_en = 1'b0;
    logic [7:0] count = 8'd8;
    logic       safe_sel = 1'b0;
    logic [4:0] safe_code = 5'h1A, strap_code = 5'h05, norm_code = 5'h03;
    logic [4:0] code;
    logic       alarm;
    int         n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    clkwd_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .unit_tick_i(tick), .kick_i(kick),
        .alarm_clr_i(clr), .strap_en_i(strap_en), .cfg_sw_ovr_i(sw_ovr),
        .cfg_sw_en_i(sw_en), .cfg_count_i(count), .cfg_safe_sel_i(safe_sel),
        .cfg_safe_code_i(safe_code), .strap_code_i(strap_code),
        .norm_code_i(norm_code), .freq_code_o(code), .alarm_o(alarm)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic edge1();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 alarm", alarm, 0);
        check("R1 code", code, norm_code);
    endtask

    task automatic t_expire_and_clear();
        count = 8'd3; strap_en = 1'b1; edge1(); edge1();
        ticks(2);
        check("R3 before expiry", alarm, 0);
        check("R8 normal code", code, norm_code);
        ticks(1);
        check("R3 expiry", alarm, 1);
        check("R5 alarm", alarm, 1);
        check("R6 strap safe", code, strap_code);
        kick = 1'b1; edge1(); kick = 1'b0;
        ticks(2);
        check("R9 sticky", alarm, 1);
        safe_sel = 1'b1; #1;
        check("R7 programmed safe", code, safe_code);
        clr = 1'b1; edge1(); clr = 1'b0;
        check("R10 cleared", alarm, 0);
        check("R8 code back", code, norm_code);
        ticks(2);
        check("R10 restart partial", alarm, 0);
        ticks(1);
        check("R10 restart full", alarm, 1);
    endtask

    task automatic t_kick();
        strap_en = 1'b0; edge1();
        check("R11 disarm clears", alarm, 0);
        count = 8'd4; strap_en = 1'b1; edge1();
        ticks(3);
        kick = 1'b1; edge1(); kick = 1'b0;
        ticks(3);
        check("R4 reload", alarm, 0);
        @(negedge clk) begin tick = 1'b1; kick = 1'b1; end
        @(negedge clk) begin tick = 1'b0; kick = 1'b0; end
        ticks(3);
        check("R4 kick wins over tick", alarm, 0);
        ticks(1);
        check("R4 expiry after kick", alarm, 1);
    endtask

    task automatic t_override();
        strap_en = 1'b1; sw_ovr = 1'b1; sw_en = 1'b0; count = 8'd2; edge1();
        check("R2 sw disables", alarm, 0);
        ticks(6);
        check("R13 ticks ignored", alarm, 0);
        strap_en = 1'b0; sw_en = 1'b1; edge1();
        ticks(1);
        check("R2 sw enables partial", alarm, 0);
        ticks(1);
        check("R2 sw enables expiry", alarm, 1);
    endtask

    task automatic t_zero();
        sw_en = 1'b0; edge1();
        check("R11 disabled", alarm, 0);
        count = 8'd0; sw_en = 1'b1; edge1();
        check("R12 zero immediate", alarm, 1);
        safe_sel = 1'b0; #1;
        check("R6 strap safe again", code, strap_code);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                edge1();
                t_reset();
                t_expire_and_clear();
                t_kick();
                t_override();
                t_zero();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule